// File: doc/BRIEF.md
# Long-Descriptor Page Table Walker

This block turns a 32-bit virtual address into a 40-bit physical address. It does this by reading 64-bit descriptors from a hierarchy of translation tables in memory. A walk begins with a one-cycle start strobe. The strobe samples the virtual address, a 32-bit translation-control word and two 64-bit table base registers.

The walker first decides which of two address regions covers the virtual address. Each region can be sized through its own 3-bit field, and each region selects one base register. The walker then computes the first descriptor address and issues single 64-bit reads, one at a time, on a simple request/response port. Table entries lead it down one more level. A block or page entry ends the walk. An invalid entry also ends the walk.

Completion is signalled by a one-cycle done pulse. With the pulse come:
- a fault flag;
- the level reached;
- the physical address;
- the page size in bytes;
- the final descriptor;
- the table attribute bits, ORed together across the levels walked.

Top module: `ldw_walker`

## Requirements
- R1: Reset, applied at any time, returns the walker to idle: `mem_req_o`, `done_o` and `fault_o` are low until the next accepted start.
- R2: The size fields are s0 = control[2:0] and s1 = control[18:16]. The base register is chosen by these rules, in priority order:
  1. Base 0 if s0 is nonzero and the top s0 address bits are all zero.
  2. Else base 1 if s1 is nonzero and the top s1 bits are all one.
  3. Else base 0 if s0 is zero.
  4. Else base 1 if s1 is zero.
  5. Else the walk ends in a fault at level 1 with no memory read.
- R3: When the selected region's disable bit is set, the walk ends in a fault at level 1 with no memory read. The disable bit is control[7] for base 0 and control[23] for base 1.
- R4: Let s be the selected size. For s > 1 the walk starts at level 2 with n = 14 - s; otherwise it starts at level 1 with n = 5 - s. The table base is base-register bits [39:0] with bits [n-1:0] cleared. The virtual address used for indexing has its top s bits cleared.
- R5: At level L the read address is the current table base ORed with ((masked vaddr >> 9*(4-L)) & 0xFF8). Every read address is therefore 8-byte aligned.
- R6: A descriptor with bit 0 clear, or a level-3 descriptor with bit 1 clear, ends the walk with a fault at the current level.
- R7: A valid descriptor with bit 1 set at level 1 or 2 is a table entry. It has three effects:
  - descriptor bits [39:12] with zero low bits become the next table base;
  - descriptor bits [63:59] are ORed into the 5-bit attribute output;
  - the level increments.
- R8: A block entry (level 1 or 2, bit 1 clear) or a page entry (level 3, bit 1 set) ends the walk without fault. Its page size is 2^(39-9*level) bytes: 0x40000000, 0x200000 or 0x1000. Its physical address is descriptor bits [39:12] with zero low bits, ORed with the masked virtual address bits below the page size.
- R9: At most one read is outstanding. `mem_req_o` is a one-cycle pulse, and the next request comes only after `mem_valid_i` has returned the data.
- R10: A start strobe while a walk is in progress is ignored and does not change that walk's result.
- R11: `done_o` is a one-cycle pulse. `fault_o`, `level_o`, `paddr_o`, `page_size_o`, `desc_o` and `tattr_o` hold the walk's result from that pulse until the next start. `desc_o` carries the last descriptor read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| vaddr_i | input | 32 | Virtual address to translate |
| ctrl_i | input | 32 | Translation control: region sizes and walk-disable bits |
| base0_i | input | 64 | Table base register for the low region |
| base1_i | input | 64 | Table base register for the high region |
| mem_req_o | output | 1 | One-cycle descriptor read request |
| mem_addr_o | output | 40 | Descriptor read address |
| mem_valid_i | input | 1 | Read data valid |
| mem_data_i | input | 64 | Descriptor read data |
| done_o | output | 1 | Walk-complete pulse |
| fault_o | output | 1 | Translation fault |
| level_o | output | 2 | Level reached (1 to 3) |
| paddr_o | output | 40 | Translated physical address |
| page_size_o | output | 32 | Mapping size in bytes |
| desc_o | output | 64 | Last descriptor read |
| tattr_o | output | 5 | Table attributes ORed across levels |

## Verification
Some properties are checked on every cycle:
- read requests are single-cycle and 8-byte aligned;
- done is a single-cycle pulse;
- the captured address stays stable while busy;
- a table entry is followed by a request one level lower;
- a disabled or gap region completes at level 1 without a read;
- a fault never reports level 0;
- the reported page size always matches the reported level.

Other behaviours are shown only by the bench scenarios:
- the selection priority between the two regions;
- the exact first-descriptor address for each size;
- the index bits taken at each level;
- attribute accumulation;
- the final physical address;
- rejection of a second start;
- reset in the middle of a walk.

// File: rtl/ldw_pkg.sv
package ldw_pkg;
    localparam int unsigned VA_W     = 32;
    localparam int unsigned CTL_W    = 32;
    localparam int unsigned PA_W     = 40;
    localparam int unsigned DESC_W   = 64;
    localparam int unsigned LVL_W    = 2;
    localparam int unsigned ATTR_W   = 5;
    localparam int unsigned SZ_W     = 3;
    localparam int unsigned PSZ_W    = 32;
    localparam int unsigned SH_W     = 5;
    localparam int unsigned N_W      = 4;

    // control word field positions (decoded by the region selector)
    localparam int unsigned SZ0_LSB  = 0;
    localparam int unsigned SZ1_LSB  = 16;
    localparam int unsigned OFF0_BIT = 7;
    localparam int unsigned OFF1_BIT = 23;

    // descriptor format
    localparam int unsigned GRAN_SH  = 12;
    localparam int unsigned IDX_W    = 9;
    localparam int unsigned WORD_SH  = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } walk_state_e;

    typedef struct packed {
        walk_state_e         st;
        logic [LVL_W-1:0]    lvl;
        logic [PA_W-1:0]     tbase;
        logic [VA_W-1:0]     va;
        logic [ATTR_W-1:0]   attr;
        logic                flt;
        logic [PA_W-1:0]     pa;
        logic [PSZ_W-1:0]    psz;
        logic [DESC_W-1:0]   desc;
    } walk_regs_t;
endpackage

// File: rtl/ldw_region_sel.sv
module ldw_region_sel
    import ldw_pkg::*;
(
    input  logic [VA_W-1:0]   vaddr_i,
    input  logic [CTL_W-1:0]  ctrl_i,
    input  logic [DESC_W-1:0] base0_i,
    input  logic [DESC_W-1:0] base1_i,
    output logic              gap_o,
    output logic              off_o,
    output logic [LVL_W-1:0]  lvl_o,
    output logic [PA_W-1:0]   tbase_o,
    output logic [VA_W-1:0]   va_o
);
    localparam logic [VA_W-1:0] ONES = '1;

    logic [SZ_W-1:0]   s0, s1, sz;
    logic [VA_W-1:0]   hi0, hi1;
    logic              hit0, hit1, pick1;
    logic [N_W-1:0]    n;
    logic [DESC_W-1:0] base;

    always_comb begin
        s0    = ctrl_i[SZ0_LSB +: SZ_W];
        s1    = ctrl_i[SZ1_LSB +: SZ_W];
        hi0   = ~(ONES >> s0);
        hi1   = ~(ONES >> s1);
        hit0  = (s0 != '0) && ((vaddr_i & hi0) == '0);
        hit1  = (s1 != '0) && ((~vaddr_i & hi1) == '0);
        gap_o = 1'b0;
        pick1 = 1'b0;
        if (hit0)            pick1 = 1'b0;
        else if (hit1)       pick1 = 1'b1;
        else if (s0 == '0)   pick1 = 1'b0;
        else if (s1 == '0)   pick1 = 1'b1;
        else                 gap_o = 1'b1;

        sz    = pick1 ? s1 : s0;
        off_o = pick1 ? ctrl_i[OFF1_BIT] : ctrl_i[OFF0_BIT];
        base  = pick1 ? base1_i : base0_i;

        if (sz > 3'd1) begin
            lvl_o = 2'd2;
            n     = 4'd14 - {1'b0, sz};
        end else begin
            lvl_o = 2'd1;
            n     = 4'd5 - {1'b0, sz};
        end
        tbase_o = base[PA_W-1:0] & ({PA_W{1'b1}} << n);
        va_o    = vaddr_i & (ONES >> sz);
    end

    logic unused_sel_bits;
    assign unused_sel_bits = ^{ctrl_i, base[DESC_W-1:PA_W]};
endmodule

// File: rtl/ldw_desc_addr.sv
module ldw_desc_addr
    import ldw_pkg::*;
(
    input  logic [PA_W-1:0]  tbase_i,
    input  logic [VA_W-1:0]  va_i,
    input  logic [LVL_W-1:0] lvl_i,
    output logic [PA_W-1:0]  addr_o
);
    localparam logic [VA_W-1:0] IDX_MASK = VA_W'(((1 << IDX_W) - 1) << WORD_SH);

    logic [SH_W-1:0] sh;
    logic [VA_W-1:0] idx;

    always_comb begin
        case (lvl_i)
            2'd1:    sh = SH_W'(IDX_W * 3);
            2'd2:    sh = SH_W'(IDX_W * 2);
            default: sh = SH_W'(IDX_W * 1);
        endcase
        idx    = (va_i >> sh) & IDX_MASK;
        addr_o = tbase_i | {{(PA_W-VA_W){1'b0}}, idx};
    end
endmodule

// File: rtl/ldw_desc_decode.sv
module ldw_desc_decode
    import ldw_pkg::*;
(
    input  logic [DESC_W-1:0] desc_i,
    input  logic [LVL_W-1:0]  lvl_i,
    input  logic [VA_W-1:0]   va_i,
    output logic              bad_o,
    output logic              table_o,
    output logic [PA_W-1:0]   next_o,
    output logic [ATTR_W-1:0] attr_o,
    output logic [PA_W-1:0]   pa_o,
    output logic [PSZ_W-1:0]  psz_o
);
    localparam logic [PSZ_W-1:0] ONE = {{(PSZ_W-1){1'b0}}, 1'b1};

    logic            last;
    logic [SH_W-1:0] offw;
    logic [VA_W-1:0] offm;

    always_comb begin
        last    = (lvl_i == 2'd3);
        bad_o   = !desc_i[0] || (!desc_i[1] && last);
        table_o = desc_i[1] && !last;
        next_o  = {desc_i[PA_W-1:GRAN_SH], {GRAN_SH{1'b0}}};
        attr_o  = desc_i[DESC_W-1 -: ATTR_W];
        case (lvl_i)
            2'd1:    offw = SH_W'(GRAN_SH + 2*IDX_W);
            2'd2:    offw = SH_W'(GRAN_SH + IDX_W);
            default: offw = SH_W'(GRAN_SH);
        endcase
        psz_o = ONE << offw;
        offm  = va_i & (psz_o - ONE);
        pa_o  = next_o | {{(PA_W-VA_W){1'b0}}, offm};
    end

    logic unused_desc_bits;
    assign unused_desc_bits = ^{desc_i[DESC_W-ATTR_W-1:PA_W], desc_i[GRAN_SH-1:2]};
endmodule

// File: rtl/ldw_walker.sv
module ldw_walker
    import ldw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       vaddr_i,
    input  logic [31:0]       ctrl_i,
    input  logic [63:0]       base0_i,
    input  logic [63:0]       base1_i,
    output logic              mem_req_o,
    output logic [39:0]       mem_addr_o,
    input  logic              mem_valid_i,
    input  logic [63:0]       mem_data_i,
    output logic              done_o,
    output logic              fault_o,
    output logic [1:0]        level_o,
    output logic [39:0]       paddr_o,
    output logic [31:0]       page_size_o,
    output logic [63:0]       desc_o,
    output logic [4:0]        tattr_o
);
    walk_regs_t r_d, r_q;

    logic              sel_gap, sel_off;
    logic [LVL_W-1:0]  sel_lvl;
    logic [PA_W-1:0]   sel_tbase;
    logic [VA_W-1:0]   sel_va;
    logic [PA_W-1:0]   rd_addr;
    logic              dec_bad, dec_table;
    logic [PA_W-1:0]   dec_next, dec_pa;
    logic [ATTR_W-1:0] dec_attr;
    logic [PSZ_W-1:0]  dec_psz;

    ldw_region_sel u_sel (
        .vaddr_i (vaddr_i),
        .ctrl_i  (ctrl_i),
        .base0_i (base0_i),
        .base1_i (base1_i),
        .gap_o   (sel_gap),
        .off_o   (sel_off),
        .lvl_o   (sel_lvl),
        .tbase_o (sel_tbase),
        .va_o    (sel_va)
    );

    ldw_desc_addr u_addr (
        .tbase_i (r_q.tbase),
        .va_i    (r_q.va),
        .lvl_i   (r_q.lvl),
        .addr_o  (rd_addr)
    );

    ldw_desc_decode u_dec (
        .desc_i  (mem_data_i),
        .lvl_i   (r_q.lvl),
        .va_i    (r_q.va),
        .bad_o   (dec_bad),
        .table_o (dec_table),
        .next_o  (dec_next),
        .attr_o  (dec_attr),
        .pa_o    (dec_pa),
        .psz_o   (dec_psz)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.va    = sel_va;
                    r_d.tbase = sel_tbase;
                    r_d.attr  = '0;
                    r_d.pa    = '0;
                    r_d.psz   = '0;
                    r_d.desc  = '0;
                    if (sel_gap || sel_off) begin
                        r_d.flt = 1'b1;
                        r_d.lvl = 2'd1;
                        r_d.st  = ST_DONE;
                    end else begin
                        r_d.flt = 1'b0;
                        r_d.lvl = sel_lvl;
                        r_d.st  = ST_REQ;
                    end
                end
            end
            ST_REQ: r_d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_valid_i) begin
                    r_d.desc = mem_data_i;
                    if (dec_bad) begin
                        r_d.flt = 1'b1;
                        r_d.st  = ST_DONE;
                    end else if (dec_table) begin
                        r_d.tbase = dec_next;
                        r_d.attr  = r_q.attr | dec_attr;
                        r_d.lvl   = r_q.lvl + 2'd1;
                        r_d.st    = ST_REQ;
                    end else begin
                        r_d.pa  = dec_pa;
                        r_d.psz = dec_psz;
                        r_d.st  = ST_DONE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_req_o   = (r_q.st == ST_REQ);
    assign mem_addr_o  = rd_addr;
    assign done_o      = (r_q.st == ST_DONE);
    assign fault_o     = r_q.flt;
    assign level_o     = r_q.lvl;
    assign paddr_o     = r_q.pa;
    assign page_size_o = r_q.psz;
    assign desc_o      = r_q.desc;
    assign tattr_o     = r_q.attr;

    // ---------------- assertions ----------------
    p_req_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);

    p_addr_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[WORD_SH-1:0] == '0));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_hold_va_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |=> $stable(r_q.va));

    p_early_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && start_i && (sel_gap || sel_off))
        |=> (done_o && fault_o && level_o == 2'd1 && !mem_req_o));

    p_table_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT && mem_valid_i && !dec_bad && dec_table)
        |=> (mem_req_o && level_o == $past(level_o) + 2'd1));

    p_fault_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o) |-> (level_o != 2'd0));

    p_page_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fault_o) |-> ($countones(page_size_o) == 1 &&
            page_size_o == (level_o == 2'd1 ? 32'h4000_0000 :
                            level_o == 2'd2 ? 32'h0020_0000 : 32'h0000_1000)));
endmodule

// File: tb/sim_ldw_walker.sv
`timescale 1ns/1ps
module sim_ldw_walker;
    localparam int NV = 10;

    typedef struct packed {
        logic [31:0] va;
        logic [31:0] ctrl;
        logic [63:0] b0;
        logic [63:0] b1;
        logic [63:0] d0;
        logic [63:0] d1;
        logic [63:0] d2;
        logic [39:0] a0;
        logic [39:0] a1;
        logic [39:0] a2;
        logic [1:0]  nrd;
        logic        flt;
        logic [1:0]  lvl;
        logic [39:0] pa;
        logic [31:0] psz;
        logic [4:0]  attr;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        // 0: R8 level-1 block, base 0 by default
        '{32'hC020_1ABC, 32'h0, 64'h12_3456_7000, 64'h0, 64'h40_0000_0001, 64'h0, 64'h0,
          40'h12_3456_7018, 40'h0, 40'h0, 2'd1, 1'b0, 2'd1, 40'h40_0020_1ABC, 32'h4000_0000, 5'h0},
        // 1: R7 three-level walk with attribute accumulation
        '{32'h0040_3123, 32'h0, 64'h1000, 64'h0, 64'h0800_0000_0000_2003, 64'h1000_0000_0000_3003,
          64'hAB_CDEF_5003, 40'h1000, 40'h2010, 40'h3018, 2'd3, 1'b0, 2'd3, 40'hAB_CDEF_5123, 32'h1000, 5'h3},
        // 2: R4 size 2 starts at level 2, base aligned to 4 KiB
        '{32'h1234_5678, 32'h2, 64'h5_5FFF, 64'h0, 64'h8060_0001, 64'h0, 64'h0,
          40'h5_5488, 40'h0, 40'h0, 2'd1, 1'b0, 2'd2, 40'h8074_5678, 32'h0020_0000, 5'h0},
        // 3: R2 gap between both sized regions
        '{32'h4000_0000, 32'h0002_0002, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0,
          40'h0, 40'h0, 40'h0, 2'd0, 1'b1, 2'd1, 40'h0, 32'h0, 5'h0},
        // 4: R2 high region via base 1, R6 invalid at level 2
        '{32'hC000_5000, 32'h0002_0002, 64'h0, 64'h7_7000, 64'h0, 64'h0, 64'h0,
          40'h7_7000, 40'h0, 40'h0, 2'd1, 1'b1, 2'd2, 40'h0, 32'h0, 5'h0},
        // 5: R3 base 0 disabled
        '{32'h1234_0000, 32'h80, 64'h1000, 64'h0, 64'h0, 64'h0, 64'h0,
          40'h0, 40'h0, 40'h0, 2'd0, 1'b1, 2'd1, 40'h0, 32'h0, 5'h0},
        // 6: R6 reserved encoding at level 3
        '{32'h0, 32'h0, 64'h1000, 64'h0, 64'h2003, 64'h3003, 64'h1,
          40'h1000, 40'h2000, 40'h3000, 2'd3, 1'b1, 2'd3, 40'h0, 32'h0, 5'h0},
        // 7: R2 all-ones top bit picks base 1, R4 n=4 alignment
        '{32'h8000_0000, 32'h0001_0000, 64'h0, 64'h9ABC, 64'hC000_0001, 64'h0, 64'h0,
          40'h9AB0, 40'h0, 40'h0, 2'd1, 1'b0, 2'd1, 40'hC000_0000, 32'h4000_0000, 5'h0},
        // 8: R2 zero size0 takes everything outside region 1
        '{32'h7000_0123, 32'h0001_0000, 64'h5000, 64'h9ABC, 64'h1_0000_0001, 64'h0, 64'h0,
          40'h5008, 40'h0, 40'h0, 2'd1, 1'b0, 2'd1, 40'h1_3000_0123, 32'h4000_0000, 5'h0},
        // 9: R3 base 1 disabled
        '{32'h8000_0000, 32'h0081_0000, 64'h0, 64'h9ABC, 64'h0, 64'h0, 64'h0,
          40'h0, 40'h0, 40'h0, 2'd0, 1'b1, 2'd1, 40'h0, 32'h0, 5'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] vaddr_i = '0;
    logic [31:0] ctrl_i = '0;
    logic [63:0] base0_i = '0;
    logic [63:0] base1_i = '0;
    logic        mem_req_o;
    logic [39:0] mem_addr_o;
    logic        mem_valid_i = 1'b0;
    logic [63:0] mem_data_i = '0;
    logic        done_o, fault_o;
    logic [1:0]  level_o;
    logic [39:0] paddr_o;
    logic [31:0] page_size_o;
    logic [63:0] desc_o;
    logic [4:0]  tattr_o;

    int checks = 0;
    int fails  = 0;

    int          nrd_seen;
    bit          got_done;
    bit          overlap;
    logic [39:0] rd_log [4];

    always #10 clk = ~clk;

    ldw_walker u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vaddr_i(vaddr_i), .ctrl_i(ctrl_i),
        .base0_i(base0_i), .base1_i(base1_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_valid_i(mem_valid_i), .mem_data_i(mem_data_i), .done_o(done_o), .fault_o(fault_o),
        .level_o(level_o), .paddr_o(paddr_o), .page_size_o(page_size_o), .desc_o(desc_o),
        .tattr_o(tattr_o)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [63:0] dsel(input vec_t v, input int i);
        if (i == 0)      return v.d0;
        else if (i == 1) return v.d1;
        else             return v.d2;
    endfunction

    function automatic logic [39:0] asel(input vec_t v, input int i);
        if (i == 0)      return v.a0;
        else if (i == 1) return v.a1;
        else             return v.a2;
    endfunction

    // drives one walk and plays the memory; optional second start mid-walk
    task automatic run_walk(input vec_t v, input bit interfere);
        bit pend;
        pend = 1'b0;
        nrd_seen = 0;
        got_done = 1'b0;
        overlap = 1'b0;
        @(negedge clk);
        vaddr_i = v.va; ctrl_i = v.ctrl; base0_i = v.b0; base1_i = v.b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < 60 && !got_done; c++) begin
            if (interfere && c == 2) begin
                start_i = 1'b1;
                vaddr_i = 32'hFFFF_F000;
                ctrl_i  = 32'h0002_0002;
            end else begin
                start_i = 1'b0;
            end
            mem_valid_i = 1'b0;
            if (pend) begin
                mem_valid_i = 1'b1;
                mem_data_i  = dsel(v, nrd_seen - 1);
                pend = 1'b0;
            end
            if (mem_req_o) begin
                if (pend) overlap = 1'b1;
                if (nrd_seen < 4) rd_log[nrd_seen] = mem_addr_o;
                nrd_seen++;
                pend = 1'b1;
            end
            if (done_o) got_done = 1'b1;
            else @(negedge clk);
        end
        start_i = 1'b0;
        mem_valid_i = 1'b0;
    endtask

    task automatic check_result(input vec_t v, input int k);
        chk($sformatf("R11 v%0d done seen", k), {63'd0, got_done}, 64'd1);
        chk($sformatf("R9 v%0d no overlapping read", k), {63'd0, overlap}, 64'd0);
        chk($sformatf("R2 R3 R6 v%0d fault", k), {63'd0, fault_o}, {63'd0, v.flt});
        chk($sformatf("R6 R7 v%0d level", k), {62'd0, level_o}, {62'd0, v.lvl});
        chk($sformatf("R3 R9 v%0d read count", k), 64'(nrd_seen), {62'd0, v.nrd});
        for (int i = 0; i < int'(v.nrd) && i < nrd_seen; i++)
            chk($sformatf("R4 R5 v%0d read %0d address", k, i), {24'd0, rd_log[i]}, {24'd0, asel(v, i)});
        if (!v.flt) begin
            chk($sformatf("R8 v%0d paddr", k), {24'd0, paddr_o}, {24'd0, v.pa});
            chk($sformatf("R8 v%0d page size", k), {32'd0, page_size_o}, {32'd0, v.psz});
            chk($sformatf("R7 v%0d table attrs", k), {59'd0, tattr_o}, {59'd0, v.attr});
            chk($sformatf("R11 v%0d final descriptor", k), desc_o, dsel(v, int'(v.nrd) - 1));
        end
        @(negedge clk);
        chk($sformatf("R11 v%0d done is one cycle", k), {63'd0, done_o}, 64'd0);
        chk($sformatf("R11 v%0d result held", k), {63'd0, fault_o}, {63'd0, v.flt});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 req low in reset", {63'd0, mem_req_o}, 64'd0);
        chk("R1 done low in reset", {63'd0, done_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req low after reset", {63'd0, mem_req_o}, 64'd0);
        chk("R1 fault low after reset", {63'd0, fault_o}, 64'd0);

        // vector table
        for (int k = 0; k < NV; k++) begin
            run_walk(VEC[k], 1'b0);
            check_result(VEC[k], k);
        end

        // R10: second start during a walk is ignored
        run_walk(VEC[1], 1'b1);
        check_result(VEC[1], 100);
        for (int i = 0; i < 5; i++) begin
            chk("R10 no walk from ignored start", {62'd0, mem_req_o, done_o}, 64'd0);
            @(negedge clk);
        end

        // R1: reset in the middle of a walk
        vaddr_i = VEC[1].va; ctrl_i = VEC[1].ctrl; base0_i = VEC[1].b0; base1_i = VEC[1].b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R1 walk started before reset", {63'd0, mem_req_o}, 64'd1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-walk reset clears req/done", {62'd0, mem_req_o, done_o}, 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 stays idle after reset", {62'd0, mem_req_o, done_o}, 64'd0);
        run_walk(VEC[7], 1'b0);
        check_result(VEC[7], 200);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule